// File: doc/BRIEF.md
# Debug-Controlled No-Allocate Data Cache

This block is a small direct-mapped, write-back cache that sits between one requester and a next-level memory port. Each line holds one data word, a tag, a valid bit and a dirty bit. Under normal operation a miss allocates: any dirty victim is first written out, then the line is filled (reads) or installed directly from the write data (writes).

A two-bit allocation-control register lets a debugger make its own accesses lookup-only while the core is halted. Bit 0 governs data/unified accesses and bit 1 governs instruction-path accesses. When the debug-mode input is high, the access is flagged as debugger-issued and the selected bit is 0, the access still looks up the cache. A hit is served from the line, and a write hit updates the line and marks it dirty. A miss goes straight to the next level: the read data is passed through and a write is forwarded, with no fill and no eviction. Clean and invalidate maintenance work by index and ignore the control bits. Because the control bits reset to 0, a debugger must program the register before it relies on normal allocation for its own accesses.

The requester holds `req_valid` and its request fields until `req_ready` pulses for one cycle. In that same cycle `rsp_rdata` carries the read result. The next-level port uses a `mem_valid`/`mem_ready` handshake in which read data is taken in the accepting cycle.

Top module: `dbg_nalloc_cache`

## Requirements
- R1: The control register resets to 0. A write stores `ctl_wdata` masked by parameter `IMPL_MASK`, and bits outside the mask always read 0. Bit 0 selects the data/unified path and bit 1 the instruction path (`req_instr`=1).
- R2: A read hit raises `req_ready` in the cycle the request is presented, with the line's data on `rsp_rdata`, and makes no next-level transaction, in any mode.
- R3: A read miss with allocation enabled fetches the word from the next level, returns it to the requester, and installs it, so the next read of that address hits.
- R4: An allocating miss whose victim line is valid and dirty first issues a next-level write of the victim's address and data, then proceeds with the miss.
- R5: An access is no-allocate exactly when `dbg_mode`=1, `req_dbg`=1 and the control bit selected by `req_instr` is 0. Otherwise it allocates normally.
- R6: A no-allocate read miss returns next-level data and leaves the indexed line's valid, tag, data and dirty state unchanged, with no write-back. A repeat of the same read misses again.
- R7: A no-allocate write hit updates the line and sets its dirty bit without any next-level transaction.
- R8: A no-allocate write miss is forwarded as exactly one next-level write to the request address and does not disturb the indexed line.
- R9: With `dbg_mode`=0 or `req_dbg`=0, or when the selected control bit is 1, accesses allocate on miss.
- R10: Op CLEAN (`req_op`=2) writes back the line at the address's index if it is valid and dirty, and clears its dirty bit. A clean or invalid line produces no traffic. The control bits do not change this.
- R11: Op INVAL (`req_op`=3) clears the line at the address's index in the request cycle, without write-back.
- R12: An allocating write miss installs the write data as a dirty line without reading the next level. Ops: `req_op` 0 = READ, 1 = WRITE.
- R13: Once `mem_valid` is raised, it stays high with `mem_we`, `mem_addr` and `mem_wdata` stable until `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_mode | input | 1 | Core is in debug (halted) state |
| ctl_we | input | 1 | Write strobe for the allocation-control register |
| ctl_wdata | input | 2 | Control write data (bit 0 data, bit 1 instruction) |
| ctl_rdata | output | 2 | Control register read value |
| req_valid | input | 1 | Request present, held until `req_ready` |
| req_ready | output | 1 | One-cycle completion of the held request |
| req_op | input | 2 | 0 read, 1 write, 2 clean, 3 invalidate |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_dbg | input | 1 | Access issued by the debugger |
| req_instr | input | 1 | Access belongs to the instruction path |
| rsp_rdata | output | DATA_W | Read data, valid with `req_ready` |
| mem_valid | output | 1 | Next-level request valid |
| mem_ready | input | 1 | Next-level accepts / completes |
| mem_we | output | 1 | Next-level write (1) or read (0) |
| mem_addr | output | ADDR_W | Next-level word address |
| mem_wdata | output | DATA_W | Next-level write data |
| mem_rdata | input | DATA_W | Next-level read data, valid with `mem_ready` |

## Verification
The bound checker watches every cycle for the masking and reset of the control bits and for the hold rule on the next-level handshake. It also checks that a no-allocate access only ever sends next-level traffic for its own address, in the right direction (never a victim write-back), that invalidate completes locally, and that clean only writes back lines at its index. Whether the line was really left untouched or really replaced can only be seen over several requests. The bench shows this by counting next-level reads after a probe access: a re-read of the previously resident address costs zero fetches after a no-allocate miss and one after an allocating miss. It does this for every combination of debug mode, debugger flag, path select and control value. Directed scenarios cover dirty write-back on eviction, lost data after invalidating a dirty line, and clean under no-allocate. In all of them every read is compared with a reference memory.

// File: rtl/dnc_pkg.sv
package dnc_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_CLEAN = 2'd2,
        OP_INVAL = 2'd3
    } dnc_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_MISS,
        ST_BYPASS,
        ST_CLEAN
    } dnc_state_e;

    localparam int CTL_BITS = 2;
    localparam int CTL_DATA = 0;
    localparam int CTL_INSTR = 1;

    // Allocation is suppressed only for debugger accesses in debug state
    // whose path-select control bit is clear.
    function automatic logic alloc_ok(input logic dm, input logic from_dbg,
                                      input logic instr,
                                      input logic [CTL_BITS-1:0] ctl);
        logic sel;
        sel = instr ? ctl[CTL_INSTR] : ctl[CTL_DATA];
        return !(dm && from_dbg && !sel);
    endfunction

endpackage

// File: rtl/dnc_ctl_reg.sv
module dnc_ctl_reg
    import dnc_pkg::*;
#(
    parameter logic [CTL_BITS-1:0] IMPL_MASK = 2'b11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [CTL_BITS-1:0] wdata,
    output logic [CTL_BITS-1:0] rdata
);

    for (genvar b = 0; b < CTL_BITS; b++) begin : g_bit
        if (IMPL_MASK[b]) begin : g_impl
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    bit_q <= 1'b0;
                end else if (we) begin
                    bit_q <= wdata[b];
                end
            end
            assign rdata[b] = bit_q;
        end else begin : g_tied
            assign rdata[b] = 1'b0;
        end
    end

endmodule

// File: rtl/dnc_alloc_policy.sv
module dnc_alloc_policy
    import dnc_pkg::*;
(
    input  logic                dbg_mode,
    input  logic                req_dbg,
    input  logic                req_instr,
    input  logic [CTL_BITS-1:0] ctl,
    output logic                alloc_en
);

    always_comb begin
        alloc_en = alloc_ok(dbg_mode, req_dbg, req_instr, ctl);
    end

endmodule

// File: rtl/dnc_line_store.sv
module dnc_line_store #(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);

    localparam int LINES = 1 << IDX_W;

    logic              valid_a [LINES];
    logic              dirty_a [LINES];
    logic [TAG_W-1:0]  tag_a   [LINES];
    logic [DATA_W-1:0] data_a  [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic              v_q;
        logic              d_q;
        logic [TAG_W-1:0]  t_q;
        logic [DATA_W-1:0] w_q;
        logic              sel;

        assign sel = wr_en && (idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
                t_q <= '0;
                w_q <= '0;
            end else if (sel) begin
                v_q <= wr_valid;
                d_q <= wr_dirty;
                t_q <= wr_tag;
                w_q <= wr_data;
            end
        end

        assign valid_a[g] = v_q;
        assign dirty_a[g] = d_q;
        assign tag_a[g]   = t_q;
        assign data_a[g]  = w_q;
    end

    assign rd_valid = valid_a[idx];
    assign rd_dirty = dirty_a[idx];
    assign rd_tag   = tag_a[idx];
    assign rd_data  = data_a[idx];

endmodule

// File: rtl/dbg_nalloc_cache.sv
module dbg_nalloc_cache
    import dnc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2,
    parameter logic [1:0] IMPL_MASK = 2'b11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_mode,
    input  logic              ctl_we,
    input  logic [1:0]        ctl_wdata,
    output logic [1:0]        ctl_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_dbg,
    input  logic              req_instr,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int TAG_W = ADDR_W - IDX_W;

    dnc_state_e state_q, state_d;
    dnc_op_e    op;

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  req_tag;
    logic              alloc_en;
    logic              hit;

    logic              rd_valid, rd_dirty;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en, wr_valid, wr_dirty;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;

    assign op      = dnc_op_e'(req_op);
    assign idx     = req_addr[IDX_W-1:0];
    assign req_tag = req_addr[ADDR_W-1:IDX_W];
    assign hit     = rd_valid && (rd_tag == req_tag);

    dnc_ctl_reg #(.IMPL_MASK(IMPL_MASK)) u_ctl (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .rdata (ctl_rdata)
    );

    dnc_alloc_policy u_policy (
        .dbg_mode  (dbg_mode),
        .req_dbg   (req_dbg),
        .req_instr (req_instr),
        .ctl       (ctl_rdata),
        .alloc_en  (alloc_en)
    );

    dnc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .idx      (idx),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_valid (wr_valid),
        .wr_dirty (wr_dirty),
        .wr_tag   (wr_tag),
        .wr_data  (wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        rsp_rdata = rd_data;
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = req_addr;
        mem_wdata = req_wdata;
        wr_en     = 1'b0;
        wr_valid  = rd_valid;
        wr_dirty  = rd_dirty;
        wr_tag    = rd_tag;
        wr_data   = rd_data;

        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    case (op)
                        OP_READ, OP_WRITE: begin
                            if (hit) begin
                                req_ready = 1'b1;
                                if (op == OP_WRITE) begin
                                    wr_en    = 1'b1;
                                    wr_dirty = 1'b1;
                                    wr_data  = req_wdata;
                                end
                            end else if (!alloc_en) begin
                                state_d = ST_BYPASS;
                            end else if (rd_valid && rd_dirty) begin
                                state_d = ST_EVICT;
                            end else begin
                                state_d = ST_MISS;
                            end
                        end
                        OP_CLEAN: begin
                            if (rd_valid && rd_dirty) begin
                                state_d = ST_CLEAN;
                            end else begin
                                req_ready = 1'b1;
                            end
                        end
                        default: begin
                            wr_en     = 1'b1;
                            wr_valid  = 1'b0;
                            wr_dirty  = 1'b0;
                            req_ready = 1'b1;
                        end
                    endcase
                end
            end
            ST_EVICT, ST_CLEAN: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {rd_tag, idx};
                mem_wdata = rd_data;
                if (mem_ready) begin
                    wr_en    = 1'b1;
                    wr_dirty = 1'b0;
                    if (state_q == ST_EVICT) begin
                        state_d = ST_MISS;
                    end else begin
                        req_ready = 1'b1;
                        state_d   = ST_IDLE;
                    end
                end
            end
            ST_MISS: begin
                if (op == OP_WRITE) begin
                    wr_en     = 1'b1;
                    wr_valid  = 1'b1;
                    wr_dirty  = 1'b1;
                    wr_tag    = req_tag;
                    wr_data   = req_wdata;
                    req_ready = 1'b1;
                    state_d   = ST_IDLE;
                end else begin
                    mem_valid = 1'b1;
                    if (mem_ready) begin
                        wr_en     = 1'b1;
                        wr_valid  = 1'b1;
                        wr_dirty  = 1'b0;
                        wr_tag    = req_tag;
                        wr_data   = mem_rdata;
                        rsp_rdata = mem_rdata;
                        req_ready = 1'b1;
                        state_d   = ST_IDLE;
                    end
                end
            end
            ST_BYPASS: begin
                mem_valid = 1'b1;
                mem_we    = (op == OP_WRITE);
                if (mem_ready) begin
                    rsp_rdata = mem_rdata;
                    req_ready = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/dnc_checker.sv
module dnc_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2,
    parameter logic [1:0] IMPL_MASK = 2'b11
) (
    input logic              clk,
    input logic              rst,
    input logic              dbg_mode,
    input logic [1:0]        ctl_rdata,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_dbg,
    input logic              req_instr,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata
);

    logic no_alloc;
    assign no_alloc = dbg_mode && req_dbg &&
                      !(req_instr ? ctl_rdata[1] : ctl_rdata[0]);

    // R1
    p_ctl_mask_r1: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata & ~IMPL_MASK) == 2'b00);

    // R1
    p_ctl_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ctl_rdata == 2'b00);

    // R2
    p_ready_needs_valid_r2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> req_valid);

    // R6
    p_noalloc_own_addr_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid && no_alloc && (req_op == 2'd0 || req_op == 2'd1) && mem_valid
        |-> mem_addr == req_addr);

    // R6
    p_noalloc_read_nowb_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid && no_alloc && req_op == 2'd0 && mem_valid |-> !mem_we);

    // R8
    p_noalloc_write_fwd_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid && no_alloc && req_op == 2'd1 && mem_valid |-> mem_we);

    // R10
    p_clean_wb_index_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_op == 2'd2 && mem_valid
        |-> mem_we && mem_addr[IDX_W-1:0] == req_addr[IDX_W-1:0]);

    // R11
    p_inval_local_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_op == 2'd3 |-> req_ready && !mem_valid);

    // R13
    p_mem_hold_r13: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready
        |=> mem_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

endmodule

bind dbg_nalloc_cache dnc_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .IMPL_MASK(IMPL_MASK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dbg_mode  (dbg_mode),
    .ctl_rdata (ctl_rdata),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_dbg   (req_dbg),
    .req_instr (req_instr),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/dbg_nalloc_cache_test.sv
`timescale 1ns/1ps
module dbg_nalloc_cache_test;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int IW = 2;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dbg_mode = 1'b0;
    logic          ctl_we = 1'b0;
    logic [1:0]    ctl_wdata = 2'b00;
    logic [1:0]    ctl_rdata;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_dbg = 1'b0;
    logic          req_instr = 1'b0;
    logic [DW-1:0] rsp_rdata;
    logic          mem_valid;
    logic          mem_ready = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    // second instance with only the data-path bit implemented
    logic          m_we = 1'b0;
    logic [1:0]    m_wdata = 2'b00;
    logic [1:0]    m_rdata;
    logic          m_rr, m_mv, m_mwe;
    logic [DW-1:0] m_rsp, m_mwd;
    logic [AW-1:0] m_ma;

    always #2.5 clk = ~clk;

    dbg_nalloc_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .IMPL_MASK(2'b11)) uut (
        .clk(clk), .rst(rst), .dbg_mode(dbg_mode),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_dbg(req_dbg),
        .req_instr(req_instr), .rsp_rdata(rsp_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    dbg_nalloc_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .IMPL_MASK(2'b01)) uut_half (
        .clk(clk), .rst(rst), .dbg_mode(1'b0),
        .ctl_we(m_we), .ctl_wdata(m_wdata), .ctl_rdata(m_rdata),
        .req_valid(1'b0), .req_ready(m_rr), .req_op(2'd0),
        .req_addr('0), .req_wdata('0), .req_dbg(1'b0),
        .req_instr(1'b0), .rsp_rdata(m_rsp),
        .mem_valid(m_mv), .mem_ready(1'b0), .mem_we(m_mwe),
        .mem_addr(m_ma), .mem_wdata(m_mwd), .mem_rdata('0)
    );

    logic [DW-1:0] mem_m [NW];
    logic [DW-1:0] ref_m [NW];
    int n_rd = 0;
    int n_wr = 0;
    logic [AW-1:0] last_wa = '0;
    logic [DW-1:0] last_wd = '0;
    int lat = 0;
    int errors = 0;
    int checks = 0;
    bit done = 0;

    // next-level memory with two wait cycles per transfer
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
        end else if (mem_valid && !rst) begin
            if (lat == 2) begin
                lat = 0;
                mem_ready = 1'b1;
                if (mem_we) begin
                    mem_m[mem_addr] = mem_wdata;
                    n_wr++;
                    last_wa = mem_addr;
                    last_wd = mem_wdata;
                end else begin
                    mem_rdata = mem_m[mem_addr];
                    n_rd++;
                end
            end else begin
                lat++;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic do_req(input logic [1:0] op, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, input logic dbg,
                          input logic ins, output logic [DW-1:0] rd);
        int waited;
        @(negedge clk);
        req_op = op; req_addr = a; req_wdata = wd;
        req_dbg = dbg; req_instr = ins; req_valid = 1'b1;
        waited = 0;
        forever begin
            #1;
            if (req_ready) break;
            waited++;
            if (waited > 60) begin
                chk(0, "R13", "request never completed", 0, 1);
                break;
            end
            @(negedge clk);
        end
        rd = rsp_rdata;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic set_ctl(input logic [1:0] v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic rd_ref(input logic [AW-1:0] a, input logic dbg,
                          input logic ins, input string rq);
        logic [DW-1:0] d;
        do_req(2'd0, a, '0, dbg, ins, d);
        chk(d == ref_m[a], rq, "read data vs reference", d, ref_m[a]);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] v,
                      input logic dbg);
        logic [DW-1:0] d;
        do_req(2'd1, a, v, dbg, 1'b0, d);
        ref_m[a] = v;
    endtask

    task automatic maint(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic dbg);
        logic [DW-1:0] d;
        do_req(op, a, '0, dbg, 1'b0, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(0, "R13", "watchdog expired", 0, 1);
            finish_up();
        end
    end

    initial begin
        int r0, w0;
        logic [AW-1:0] a_x, b_x, c_x;
        for (int i = 0; i < NW; i++) begin
            mem_m[i] = DW'(i * 613 + 17);
            ref_m[i] = mem_m[i];
        end
        repeat (3) @(negedge clk);
        chk(ctl_rdata == 2'b00, "R1", "control reset value", ctl_rdata, 0);
        chk(req_ready == 1'b0 && mem_valid == 1'b0, "R2", "idle outputs in reset",
            {req_ready, mem_valid}, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ctl_rdata == 2'b00, "R1", "control after reset", ctl_rdata, 0);

        // R1: full mask and partial mask
        set_ctl(2'b11);
        chk(ctl_rdata == 2'b11, "R1", "control readback", ctl_rdata, 3);
        @(negedge clk);
        m_we = 1'b1; m_wdata = 2'b11;
        @(negedge clk);
        m_we = 1'b0;
        chk(m_rdata == 2'b01, "R1", "unimplemented bit reads zero", m_rdata, 1);
        m_we = 1'b1; m_wdata = 2'b10;
        @(negedge clk);
        m_we = 1'b0;
        chk(m_rdata == 2'b00, "R1", "unimplemented bit ignores write", m_rdata, 0);

        // R5/R6/R9/R3 sweep over every policy input combination
        for (int c = 0; c < 32; c++) begin
            logic dm, rdg, ins, exp_alloc;
            logic [1:0] cv;
            dm = c[0]; rdg = c[1]; ins = c[2]; cv = c[4:3];
            exp_alloc = !(dm && rdg && !cv[ins]);
            a_x = AW'({c[5:0], 2'(c)});
            b_x = AW'({6'(c + 32), 2'(c)});
            set_ctl(cv);
            dbg_mode = 1'b0;
            maint(2'd2, a_x, 1'b0);
            maint(2'd3, a_x, 1'b0);
            rd_ref(a_x, 1'b0, 1'b0, "R3");
            dbg_mode = dm;
            w0 = n_wr;
            rd_ref(b_x, rdg, ins, "R6");
            dbg_mode = 1'b0;
            r0 = n_rd;
            rd_ref(a_x, 1'b0, 1'b0, "R9");
            chk((n_rd - r0) == (exp_alloc ? 1 : 0), exp_alloc ? "R9" : "R5",
                "fetches when re-reading prior line", n_rd - r0, exp_alloc ? 1 : 0);
            chk(n_wr == w0, "R6", "no write-back on clean probe", n_wr - w0, 0);
        end

        a_x = 8'h11; b_x = 8'h21; c_x = 8'h31;
        dbg_mode = 1'b0;
        set_ctl(2'b00);
        maint(2'd2, a_x, 1'b0);
        maint(2'd3, a_x, 1'b0);

        // R12: allocating write miss installs without a fetch
        r0 = n_rd; w0 = n_wr;
        wr(a_x, 16'hBEEF, 1'b0);
        chk(n_rd == r0 && n_wr == w0, "R12", "write-miss traffic",
            (n_rd - r0) + (n_wr - w0), 0);
        rd_ref(a_x, 1'b0, 1'b0, "R12");
        chk(n_rd == r0, "R2", "read hit makes no fetch", n_rd - r0, 0);

        // R7: no-allocate write hit
        dbg_mode = 1'b1;
        wr(a_x, 16'h1234, 1'b1);
        chk(n_rd == r0 && n_wr == w0, "R7", "no-alloc write hit traffic",
            (n_rd - r0) + (n_wr - w0), 0);
        rd_ref(a_x, 1'b1, 1'b0, "R2");
        chk(n_rd == r0, "R2", "debug read hit makes no fetch", n_rd - r0, 0);

        // R8: no-allocate write miss forwarded
        wr(b_x, 16'h5555, 1'b1);
        chk(n_wr - w0 == 1, "R8", "forwarded write count", n_wr - w0, 1);
        chk(last_wa == b_x, "R8", "forwarded write address", last_wa, b_x);
        chk(mem_m[b_x] == 16'h5555, "R8", "next level holds write", mem_m[b_x], 16'h5555);
        chk(n_rd == r0, "R8", "no fetch on forwarded write", n_rd - r0, 0);
        dbg_mode = 1'b0;
        rd_ref(a_x, 1'b0, 1'b0, "R8");
        chk(n_rd == r0, "R8", "resident line survives", n_rd - r0, 0);

        // R6: no-allocate read miss does not evict a dirty line
        dbg_mode = 1'b1;
        w0 = n_wr;
        rd_ref(c_x, 1'b1, 1'b0, "R6");
        chk(n_rd - r0 == 1 && n_wr == w0, "R6", "no-alloc miss traffic",
            (n_rd - r0) * 16 + (n_wr - w0), 16);
        rd_ref(c_x, 1'b1, 1'b0, "R6");
        chk(n_rd - r0 == 2, "R6", "repeat no-alloc read misses again", n_rd - r0, 2);

        // R7/R10: clean under no-allocate writes back the dirty line
        w0 = n_wr;
        maint(2'd2, a_x, 1'b1);
        chk(n_wr - w0 == 1 && last_wa == a_x, "R7", "dirty line written back",
            last_wa, a_x);
        chk(mem_m[a_x] == 16'h1234, "R10", "cleaned data", mem_m[a_x], 16'h1234);
        maint(2'd2, a_x, 1'b1);
        chk(n_wr - w0 == 1, "R10", "clean of clean line is silent", n_wr - w0, 1);

        // R4: dirty victim written back before an allocating fill
        dbg_mode = 1'b0;
        wr(a_x, 16'h7777, 1'b0);
        r0 = n_rd; w0 = n_wr;
        rd_ref(b_x, 1'b0, 1'b0, "R4");
        chk(n_wr - w0 == 1 && last_wa == a_x && last_wd == 16'h7777, "R4",
            "victim write-back", last_wd, 16'h7777);
        chk(n_rd - r0 == 1, "R3", "one fill fetch", n_rd - r0, 1);
        rd_ref(b_x, 1'b0, 1'b0, "R3");
        chk(n_rd - r0 == 1, "R3", "filled line hits", n_rd - r0, 1);

        // R11: invalidate drops dirty data without write-back
        wr(b_x, 16'h9999, 1'b0);
        w0 = n_wr;
        maint(2'd3, b_x, 1'b0);
        chk(n_wr == w0, "R11", "no write-back on invalidate", n_wr - w0, 0);
        ref_m[b_x] = mem_m[b_x];
        rd_ref(b_x, 1'b0, 1'b0, "R11");
        chk(n_rd - r0 == 2, "R11", "line misses after invalidate", n_rd - r0, 2);

        // R9: debugger access with control bit set allocates
        dbg_mode = 1'b1;
        set_ctl(2'b01);
        r0 = n_rd;
        rd_ref(c_x, 1'b1, 1'b0, "R9");
        rd_ref(c_x, 1'b1, 1'b0, "R9");
        chk(n_rd - r0 == 1, "R9", "set bit gives allocation", n_rd - r0, 1);
        rd_ref(a_x, 1'b1, 1'b1, "R5");
        rd_ref(a_x, 1'b1, 1'b1, "R5");
        chk(n_rd - r0 == 3, "R5", "instruction bit clear suppresses fill", n_rd - r0, 3);

        done = 1;
        finish_up();
    end

endmodule